// File: doc/BRIEF.md
# Dual-Slot Memory-to-Memory DMA Channel

This block is a single DMA channel that copies word data from one memory region to another over a simple word-wide master port. Software programs it through a 32-bit register interface. Two buffer slots each hold a source base, a destination base and a byte count. Once started, the channel drains the active slot. When that slot's count runs out and the other slot is loaded, it moves on to the other slot without software help and raises a next-frame event. When nothing is left, it parks in a stall state and reports completion.

A bandwidth code can split the traffic into blocks of a fixed byte size, with a fixed idle gap after each block. A fill mode reads one element from the source and writes it across the whole destination block. The status register shows the control machine state, how many slots are loaded, which slot software should load next, and the done and next-frame flags. Data moves as 32-bit words. Counts must be multiples of 4, and the base addresses must be word aligned.

Top module: `dma_dual_buf_ch`

## Requirements
- R1: After reset the status register (0x0C) reads 0, the interrupt register (0x04) reads 0, `irq` is low and `mem_req` is low.
- R2: Control bit 3 enables the channel. Once it is set, the control state field (status bits 3:1) moves from idle (0) to stall (1) on the second clock edge after the write, and status bit 0 is set while in stall. Clearing bit 3 sends the machine back to idle (0). Writes to the status register have no effect.
- R3: A control write with bit 4 (start) and bit 3 set, and with bits 14:13 equal to 0, begins a transfer only while the machine is in stall and the active slot is loaded. The control field then reads memory read (2) at the next edge. In any other case the start is ignored and no memory request is issued.
- R4: Each word is read from the source current address and then written to the destination current address. After each write, both current addresses advance by 4 and the count falls by 4. Slot k has its count at 0x10+4k, its source base at 0x18+4k, its source current address at 0x24+4k and its destination base at 0x2C+4k. Slot 0's destination current address is at 0x34 and slot 1's is at 0x3C. The counts and current addresses read back live values. Writing a base also sets the matching current address.
- R5: Writing a nonzero count marks a slot as loaded, and a slot is unloaded when its count reaches 0. Status bits 5:4 give the number of loaded slots (0, 1 or 2). Status bit 12 names the slot to load next: the active slot if none is loaded, otherwise the other slot.
- R6: When the active slot's count reaches 0 and the other slot is loaded, the channel continues from the other slot. It also sets interrupt bit 2 (next-frame), which status bit 11 mirrors.
- R7: When the active slot's count reaches 0 and the other slot is not loaded, the machine enters stall with 0 slots loaded and sets status bit 6 (done), interrupt bit 1 (done) and interrupt bit 0 (stall). Entering stall on enable also sets interrupt bit 0. The done flag clears on the next accepted start.
- R8: Writing 0 to the interrupt register clears all pending bits. `irq` is the OR of pending stall, done and next-frame, each gated by control bit 0, 2 and 21 respectively.
- R9: With control bit 1 (fill) set, the channel reads one source word per slot and writes it to every destination word. The source current address does not move.
- R10: Control bits 8:5 select the block size: 0 means no gaps, 1 means 16 bytes, and codes 5 to 15 mean 32 bytes doubling up to 32768 bytes. After each full block, if the transfer has more words to move, the machine spends exactly 16 cycles in bandwidth wait (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |

## Verification
A register write lands on the clock edge that follows it. An accepted start therefore shows memory read in the status register right after that edge. Enable is registered and then seen by the control machine, so stall appears one edge later than the write. The done and next-frame flags change on the edge that accepts the last write of a slot, so the bench polls the status register once per cycle between edges and checks the flags and memory contents as soon as they flip. The bandwidth gap is measured by counting the sampled cycles that show bandwidth wait, which must total exactly 16 per block boundary.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_STALL = 3'd1,
      ST_RD    = 3'd2,
      ST_WR    = 3'd3,
      ST_GAP   = 3'd4
   } eng_state_e;

   localparam logic [7:0] OFS_CTRL = 8'h00;
   localparam logic [7:0] OFS_INT  = 8'h04;
   localparam logic [7:0] OFS_STAT = 8'h0C;

   // writable control bits: 0..3, 8:5, 14:13, 21 (bit 4 is a pulse)
   localparam logic [31:0] CTRL_WMASK = 32'h0020_61EF;

   function automatic logic [7:0] ofs_cnt(input int k);
      return 8'(8'h10 + 4 * k);
   endfunction
   function automatic logic [7:0] ofs_sbase(input int k);
      return 8'(8'h18 + 4 * k);
   endfunction
   function automatic logic [7:0] ofs_scur(input int k);
      return 8'(8'h24 + 4 * k);
   endfunction
   function automatic logic [7:0] ofs_dbase(input int k);
      return 8'(8'h2C + 4 * k);
   endfunction
   function automatic logic [7:0] ofs_dcur(input int k);
      return 8'(8'h34 + 8 * k);
   endfunction

   // block size in bytes for a bandwidth code, 0 = unthrottled
   function automatic logic [15:0] blk_size(input logic [3:0] code);
      if (code == 4'd1)
         return 16'd16;
      else if (code >= 4'd5)
         return 16'd32 << (code - 4'd5);
      else
         return 16'd0;
   endfunction

endpackage

// File: rtl/dbc_slot.sv
module dbc_slot #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_cnt,
   input  logic             wr_src,
   input  logic             wr_dst,
   input  logic [31:0]      wdata,
   input  logic             step,
   input  logic             src_inc,
   output logic [CNT_W-1:0] cnt,
   output logic [31:0]      src_base,
   output logic [31:0]      dst_base,
   output logic [31:0]      src_cur,
   output logic [31:0]      dst_cur,
   output logic             loaded,
   output logic             last
);
   localparam logic [CNT_W-1:0] WORD_B = CNT_W'(4);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         loaded <= 1'b0;
      end else if (wr_cnt) begin
         cnt    <= wdata[CNT_W-1:0];
         loaded <= (wdata[CNT_W-1:0] != '0);
      end else if (step) begin
         if (cnt > WORD_B) begin
            cnt <= cnt - WORD_B;
         end else begin
            cnt    <= '0;
            loaded <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_base <= '0;
         src_cur  <= '0;
      end else if (wr_src) begin
         src_base <= wdata;
         src_cur  <= wdata;
      end else if (step && src_inc) begin
         src_cur <= src_cur + 32'd4;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dst_base <= '0;
         dst_cur  <= '0;
      end else if (wr_dst) begin
         dst_base <= wdata;
         dst_cur  <= wdata;
      end else if (step) begin
         dst_cur <= dst_cur + 32'd4;
      end
   end

   assign last = (cnt <= WORD_B);

   // R5: a loaded slot never holds a zero count
   a_r5_loaded_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      loaded |-> (cnt != '0));

endmodule

// File: rtl/dbc_engine.sv
module dbc_engine
   import dbc_pkg::*;
#(
   parameter int unsigned GAP_CYC = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        enable,
   input  logic        start_go,
   input  logic        fill,
   input  logic [15:0] blk_bytes,
   input  logic        act_last,
   input  logic        oth_loaded,
   input  logic [31:0] src_addr,
   input  logic [31:0] dst_addr,
   input  logic [31:0] mem_rdata,
   input  logic        mem_ack,
   output eng_state_e  state,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   output logic        step,
   output logic        src_inc,
   output logic        hand_over,
   output logic        finish,
   output logic        stall_evt
);
   localparam int unsigned GW = $clog2(GAP_CYC + 1);
   localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

   logic [15:0]   blk_cnt;
   logic [15:0]   blk_cnt_nxt;
   logic          blk_end;
   logic [GW-1:0] gap_cnt;
   logic [31:0]   data_q;
   logic          have_q;

   assign blk_cnt_nxt = blk_cnt + 16'd4;
   assign blk_end     = (blk_bytes != 16'd0) && (blk_cnt_nxt == blk_bytes);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         blk_cnt <= '0;
         gap_cnt <= '0;
         data_q  <= '0;
         have_q  <= 1'b0;
      end else if (!enable) begin
         state   <= ST_IDLE;
         have_q  <= 1'b0;
         gap_cnt <= '0;
      end else begin
         case (state)
            ST_IDLE: state <= ST_STALL;
            ST_STALL: begin
               if (start_go) begin
                  state   <= ST_RD;
                  have_q  <= 1'b0;
                  blk_cnt <= '0;
               end
            end
            ST_RD: begin
               if (mem_ack) begin
                  data_q <= mem_rdata;
                  have_q <= 1'b1;
                  state  <= ST_WR;
               end
            end
            ST_WR: begin
               if (mem_ack) begin
                  blk_cnt <= blk_end ? '0 : blk_cnt_nxt;
                  if (act_last)
                     have_q <= 1'b0;
                  if (act_last && !oth_loaded)
                     state <= ST_STALL;
                  else if (blk_end)
                     state <= ST_GAP;
                  else if (fill && !act_last)
                     state <= ST_WR;
                  else
                     state <= ST_RD;
               end
            end
            ST_GAP: begin
               if (gap_cnt == GAP_LAST) begin
                  gap_cnt <= '0;
                  state   <= (fill && have_q) ? ST_WR : ST_RD;
               end else begin
                  gap_cnt <= gap_cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_req   = (state == ST_RD) || (state == ST_WR);
   assign mem_we    = (state == ST_WR);
   assign mem_addr  = (state == ST_WR) ? dst_addr : src_addr;
   assign mem_wdata = data_q;
   assign step      = (state == ST_WR) && mem_ack;
   assign src_inc   = !fill;
   assign hand_over = step && act_last && oth_loaded;
   assign finish    = step && act_last && !oth_loaded;
   assign stall_evt = ((state == ST_IDLE) && enable) || finish;

   // R10: the bandwidth wait is entered only straight after a word write
   a_r10_gap_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_GAP && $past(state) != ST_GAP) |-> $past(state) == ST_WR);

endmodule

// File: rtl/dma_dual_buf_ch.sv
module dma_dual_buf_ch
   import dbc_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned GAP_CYC = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [7:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        irq,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic [31:0] mem_rdata,
   input  logic        mem_ack
);
   localparam int unsigned NSLOT = 2;

   generate
      if (CNT_W < 4 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 4..32");
      end
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("GAP_CYC must be at least 1");
      end
   endgenerate

   logic [31:0]      ctrl_q;
   logic [2:0]       pend_q;
   logic             done_q;
   logic             active;
   eng_state_e       state;

   logic [CNT_W-1:0] cnt_a [NSLOT];
   logic [31:0]      sb_a  [NSLOT];
   logic [31:0]      db_a  [NSLOT];
   logic [31:0]      sc_a  [NSLOT];
   logic [31:0]      dc_a  [NSLOT];
   logic [NSLOT-1:0] ld_a;
   logic [NSLOT-1:0] last_a;

   logic step, src_inc, hand_over, finish, stall_evt;
   logic start_go, ctrl_wr, int_wr;
   logic act_loaded, oth_loaded, nb;
   logic [1:0]  buf_st;
   logic [31:0] status;

   assign ctrl_wr    = reg_we && (reg_addr == OFS_CTRL);
   assign int_wr     = reg_we && (reg_addr == OFS_INT);
   assign act_loaded = ld_a[active];
   assign oth_loaded = ld_a[~active];
   assign start_go   = ctrl_wr && reg_wdata[4] && reg_wdata[3] &&
                       (reg_wdata[14:13] == 2'b00) && act_loaded;

   // buffer slots
   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      dbc_slot #(.CNT_W(CNT_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_cnt   (reg_we && (reg_addr == ofs_cnt(k))),
         .wr_src   (reg_we && (reg_addr == ofs_sbase(k))),
         .wr_dst   (reg_we && (reg_addr == ofs_dbase(k))),
         .wdata    (reg_wdata),
         .step     (step && (active == 1'(k))),
         .src_inc  (src_inc),
         .cnt      (cnt_a[k]),
         .src_base (sb_a[k]),
         .dst_base (db_a[k]),
         .src_cur  (sc_a[k]),
         .dst_cur  (dc_a[k]),
         .loaded   (ld_a[k]),
         .last     (last_a[k])
      );
   end

   dbc_engine #(.GAP_CYC(GAP_CYC)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (ctrl_q[3]),
      .start_go   (start_go),
      .fill       (ctrl_q[1]),
      .blk_bytes  (blk_size(ctrl_q[8:5])),
      .act_last   (last_a[active]),
      .oth_loaded (oth_loaded),
      .src_addr   (sc_a[active]),
      .dst_addr   (dc_a[active]),
      .mem_rdata  (mem_rdata),
      .mem_ack    (mem_ack),
      .state      (state),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .step       (step),
      .src_inc    (src_inc),
      .hand_over  (hand_over),
      .finish     (finish),
      .stall_evt  (stall_evt)
   );

   // control, pending events, done flag, active slot pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         pend_q <= '0;
         done_q <= 1'b0;
         active <= 1'b0;
      end else begin
         if (ctrl_wr)
            ctrl_q <= reg_wdata & CTRL_WMASK;
         if (int_wr && reg_wdata == 32'd0)
            pend_q <= '0;
         if (stall_evt) pend_q[0] <= 1'b1;
         if (finish)    pend_q[1] <= 1'b1;
         if (hand_over) pend_q[2] <= 1'b1;
         if (start_go && state == ST_STALL)
            done_q <= 1'b0;
         else if (finish)
            done_q <= 1'b1;
         if (hand_over || finish)
            active <= ~active;
      end
   end

   assign buf_st = {1'b0, ld_a[0]} + {1'b0, ld_a[1]};
   assign nb     = (ld_a == '0) ? active : ~active;
   assign status = {19'd0, nb, pend_q[2], 4'd0, done_q, buf_st,
                    state, (state == ST_STALL)};
   assign irq    = (pend_q[0] & ctrl_q[0]) | (pend_q[1] & ctrl_q[2]) |
                   (pend_q[2] & ctrl_q[21]);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_CTRL: reg_rdata = ctrl_q;
         OFS_INT:  reg_rdata = {29'd0, pend_q};
         OFS_STAT: reg_rdata = status;
         default:  reg_rdata = '0;
      endcase
      for (int k = 0; k < NSLOT; k++) begin
         if (reg_addr == ofs_cnt(k))   reg_rdata = 32'(cnt_a[k]);
         if (reg_addr == ofs_sbase(k)) reg_rdata = sb_a[k];
         if (reg_addr == ofs_scur(k))  reg_rdata = sc_a[k];
         if (reg_addr == ofs_dbase(k)) reg_rdata = db_a[k];
         if (reg_addr == ofs_dcur(k))  reg_rdata = dc_a[k];
      end
   end

   // R2: a cleared enable forces the control machine to idle
   a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[3] |=> state == ST_IDLE);

   // R7: memory traffic only while the active slot still holds a count
   a_r7_busy_has_count: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD || state == ST_WR) |-> act_loaded);

   // R7: the done flag is never up while data is moving
   a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (state == ST_IDLE || state == ST_STALL));

   // R4: every memory access is word aligned
   a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00);

endmodule

// File: tb/tb_dma_dual_buf_ch.sv
module tb_dma_dual_buf_ch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   int errors = 0;
   int checks = 0;
   int rd_cnt = 0;
   logic [31:0] mem [256];

   always #5 clk = ~clk;

   dma_dual_buf_ch dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

   function automatic logic [31:0] pat(input int i);
      return 32'hC0DE_0000 | 32'(i);
   endfunction

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = pat(i);
   end

   // memory model: acknowledge one cycle after a request is seen
   always @(posedge clk) begin
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
         else begin
            mem_rdata <= mem[mem_addr[9:2]];
            rd_cnt    <= rd_cnt + 1;
         end
      end else begin
         mem_ack <= 1'b0;
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
      errors++;
      checks++;
      summary();
      $finish;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic load_slot(input int k, input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
      wr(8'(8'h18 + 4 * k), s);
      wr(8'(8'h2C + 4 * k), d);
      wr(8'(8'h10 + 4 * k), c);
   endtask

   // enable with ctrl value, wait for stall, clear pending, then start
   task automatic go(input logic [31:0] c);
      wr(8'h00, c);
      repeat (2) @(negedge clk);
      wr(8'h04, 32'd0);
      wr(8'h00, c | 32'h10);
   endtask

   task automatic wait_done(output int gaps);
      logic [31:0] s;
      gaps = 0;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         rd(8'h0C, s);
         if (s[3:1] == 3'd4) gaps++;
         if (s[6]) break;
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_reset();
      rd(8'h0C, v); check("R1 status", v, 32'h0);
      rd(8'h04, v); check("R1 int", v, 32'h0);
      check("R1 irq", 32'(irq), 32'h0);
      check("R1 mem_req", 32'(mem_req), 32'h0);
   endtask

   task automatic t_enable();
      logic [31:0] v;
      do_reset();
      wr(8'h00, 32'h8);
      rd(8'h0C, v); check("R2 still idle one edge after write", v, 32'h0);
      @(negedge clk);
      rd(8'h0C, v); check("R2 stall", v, 32'h3);
      rd(8'h04, v); check("R7 stall pending on enable", v, 32'h1);
      wr(8'h0C, 32'hFFFF_FFFF);
      rd(8'h0C, v); check("R2 status write ignored", v, 32'h3);
      wr(8'h00, 32'h0);
      @(negedge clk);
      rd(8'h0C, v); check("R2 back to idle", v, 32'h0);
   endtask

   task automatic t_copy();
      logic [31:0] v;
      int g;
      do_reset();
      load_slot(0, 32'h40, 32'h180, 32'd16);
      rd(8'h0C, v); check("R5 one slot loaded, next slot 1", v, 32'h1010);
      go(32'h8);
      rd(8'h0C, v); check("R3 memory read after start", 32'(v[3:1]), 32'd2);
      check("R3 request issued", 32'(mem_req), 32'h1);
      wait_done(g);
      for (int i = 0; i < 4; i++) check("R4 copied word", mem[96 + i], pat(16 + i));
      rd(8'h0C, v); check("R7 done status", v, 32'h1043);
      rd(8'h04, v); check("R7 stall and done pending", v, 32'h3);
      check("R8 irq masked", 32'(irq), 32'h0);
      rd(8'h10, v); check("R4 live count", v, 32'h0);
      rd(8'h24, v); check("R4 source current", v, 32'h50);
      rd(8'h34, v); check("R4 destination current", v, 32'h190);
      rd(8'h18, v); check("R4 source base kept", v, 32'h40);
      check("R10 full bandwidth has no gap", 32'(g), 32'd0);
      wr(8'h00, 32'h0D);
      check("R8 irq with enables", 32'(irq), 32'h1);
      wr(8'h04, 32'h0);
      rd(8'h04, v); check("R8 clear pending", v, 32'h0);
      check("R8 irq after clear", 32'(irq), 32'h0);
   endtask

   task automatic t_ignored_start();
      logic [31:0] v;
      int reqs = 0;
      do_reset();
      wr(8'h00, 32'h8);
      repeat (2) @(negedge clk);
      wr(8'h00, 32'h18);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (mem_req) reqs++;
      end
      rd(8'h0C, v); check("R3 start without slot stays stalled", 32'(v[3:1]), 32'd1);
      load_slot(0, 32'h0, 32'h3C0, 32'd8);
      wr(8'h00, 32'h2018);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (mem_req) reqs++;
      end
      rd(8'h0C, v); check("R3 start in nonzero mode ignored", 32'(v[3:1]), 32'd1);
      check("R3 no requests on ignored start", 32'(reqs), 32'd0);
   endtask

   task automatic t_pingpong();
      logic [31:0] v;
      int g;
      do_reset();
      load_slot(0, 32'h00, 32'h200, 32'd16);
      load_slot(1, 32'h20, 32'h280, 32'd8);
      rd(8'h0C, v); check("R5 two slots loaded", v, 32'h1020);
      go(32'h0020_000D);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         rd(8'h0C, v);
         if (v[11]) break;
      end
      check("R6 next-frame seen in status", 32'(v[11]), 32'h1);
      check("R6 one slot left", 32'(v[5:4]), 32'd1);
      rd(8'h04, v); check("R6 next-frame pending", v & 32'h4, 32'h4);
      check("R8 irq on next-frame", 32'(irq), 32'h1);
      wait_done(g);
      for (int i = 0; i < 4; i++) check("R6 first slot data", mem[128 + i], pat(i));
      for (int i = 0; i < 2; i++) check("R6 second slot data", mem[160 + i], pat(8 + i));
      rd(8'h04, v); check("R7 all events pending", v, 32'h7);
      rd(8'h0C, v); check("R7 final status", v, 32'h0843);
   endtask

   task automatic t_fill();
      logic [31:0] v;
      int g, r0;
      do_reset();
      load_slot(0, 32'h10, 32'h300, 32'd32);
      r0 = rd_cnt;
      go(32'h0A);
      wait_done(g);
      check("R9 single source read", 32'(rd_cnt - r0), 32'd1);
      for (int i = 0; i < 8; i++) check("R9 fill word", mem[192 + i], pat(4));
      rd(8'h24, v); check("R9 source pointer held", v, 32'h10);
   endtask

   task automatic t_bw();
      int g;
      do_reset();
      load_slot(0, 32'h00, 32'h340, 32'd32);
      go(32'h28);
      wait_done(g);
      check("R10 16-byte blocks gap cycles", 32'(g), 32'd16);
      for (int i = 0; i < 8; i++) check("R10 data under throttle", mem[208 + i], pat(i));
      do_reset();
      load_slot(0, 32'h40, 32'h380, 32'd64);
      go(32'hA8);
      wait_done(g);
      check("R10 32-byte blocks gap cycles", 32'(g), 32'd16);
      for (int i = 0; i < 16; i++) check("R10 data code 5", mem[224 + i], pat(16 + i));
   endtask

   initial begin
      t_reset();
      t_enable();
      t_copy();
      t_ignored_start();
      t_pingpong();
      t_fill();
      t_bw();
      summary();
      $finish;
   end

endmodule